// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the general-purpose registers of a 32-bit processor core. Software sees sixteen logical registers, addressed by a 4-bit index. Behind them sit 33 physical 32-bit registers. A 5-bit processor-mode input chooses which physical copy each logical index reaches. The low registers are common to every mode. The middle group has a private copy for the fast-interrupt mode. The stack pointer and the link register have one copy for each privilege bank.

There are two combinational read ports and one write port that updates on the rising clock edge. Logical index 15 is the program counter. The stored value is the address of the current instruction. A read of index 15 adds a fixed look-ahead to that address, and an instruction-set-state input chooses the look-ahead. A mode code outside the valid set is flagged. While the flag is raised the file is frozen and both read ports return zero.

Top module: `banked_regfile`

## Requirements
- R1: `bad_mode` is 0 for exactly these mode codes and 1 for every other 5-bit value: 10000 user, 10001 fast-interrupt, 10010 interrupt, 10011 supervisor, 10110 monitor, 10111 abort, 11011 undefined, 11111 system.
- R2: Indices 0 to 7 each map to a single physical register. A value written in any valid mode reads back unchanged in every valid mode.
- R3: Indices 8 to 12 have two copies each. Fast-interrupt mode reaches its own copy. Every other valid mode reaches the shared copy.
- R4: Indices 13 and 14 each have seven copies: user, fast-interrupt, interrupt, supervisor, abort, undefined and monitor. System mode reaches the user copy.
- R5: Writing index 15 stores the program counter. Reading index 15 returns the stored value plus 8 when `narrow_isa` is 0, or plus 4 when `narrow_isa` is 1.
- R6: While `bad_mode` is 1, both read ports return zero and a write leaves every register unchanged.
- R7: A write takes effect at the rising edge where `wr_en` is 1. A read of the same register in that cycle returns the old value, and the new value is visible in the next cycle.
- R8: A synchronous active-high `rst` clears all 33 physical registers to zero.
- R9: The two read ports are independent. Each port returns the register its own index selects, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 5 | Current processor mode code |
| narrow_isa | input | 1 | 1 selects 16-bit instruction state (PC read +4), 0 selects 32-bit state (+8) |
| rd_a_idx | input | 4 | Read port A logical index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B logical index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write logical index |
| wr_data | input | 32 | Write data |
| bad_mode | output | 1 | High while the mode code is invalid |

## Verification
The assertions check these rules on every cycle:
- an invalid mode zeroes both read ports and freezes the whole physical array;
- two ports that carry equal indices agree;
- a write is seen on the next cycle in the same mode, including the program-counter look-ahead;
- a low register written in one mode reads the same in any other valid mode;
- the file reads zero after reset.

Only the bench scenarios can show the banking pattern itself:
- fast-interrupt mode and the other modes keep apart the values they write to indices 8 to 12;
- each of the seven stack-pointer and link-register banks holds its own value;
- system mode lands on the user bank.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW = 32,
  parameter int IW = 4,
  parameter int MW = 5,
  parameter logic [DW-1:0] WIDE_LOOKAHEAD = 8,
  parameter logic [DW-1:0] NARROW_LOOKAHEAD = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [MW-1:0] mode,
  input  logic          narrow_isa,
  input  logic [IW-1:0] rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [IW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  output logic          bad_mode
);

  localparam int NPHYS    = 33;
  localparam int PW       = $clog2(NPHYS);
  localparam int SHARED_N = 8;
  localparam int FIQ_BASE = 13;
  localparam int SP_BASE  = 18;
  localparam int LR_BASE  = 25;
  localparam int PC_SLOT  = 32;
  localparam logic [IW-1:0] PC_IDX = IW'(15);

  localparam logic [MW-1:0] M_USR = 5'b10000;
  localparam logic [MW-1:0] M_FIQ = 5'b10001;
  localparam logic [MW-1:0] M_IRQ = 5'b10010;
  localparam logic [MW-1:0] M_SVC = 5'b10011;
  localparam logic [MW-1:0] M_MON = 5'b10110;
  localparam logic [MW-1:0] M_ABT = 5'b10111;
  localparam logic [MW-1:0] M_UND = 5'b11011;
  localparam logic [MW-1:0] M_SYS = 5'b11111;

  logic [NPHYS-1:0][DW-1:0] rf;
  logic [2:0]    bank;
  logic          valid;
  logic [PW-1:0] pa, pb, pw;
  logic [DW-1:0] pc_view;

  always_comb begin
    valid = 1'b1;
    bank  = 3'd0;
    case (mode)
      M_USR, M_SYS: bank = 3'd0;
      M_FIQ:        bank = 3'd1;
      M_IRQ:        bank = 3'd2;
      M_SVC:        bank = 3'd3;
      M_ABT:        bank = 3'd4;
      M_UND:        bank = 3'd5;
      M_MON:        bank = 3'd6;
      default: begin valid = 1'b0; bank = 3'd0; end
    endcase
  end

  assign bad_mode = ~valid;

  function automatic logic [PW-1:0] phys(input logic [2:0] bk, input logic [IW-1:0] i);
    if (i < IW'(SHARED_N))  return PW'(i);
    else if (i < IW'(13))   return (bk == 3'd1) ? PW'(FIQ_BASE) + PW'(i[2:0]) : PW'(i);
    else if (i == IW'(13))  return PW'(SP_BASE) + PW'(bk);
    else if (i == IW'(14))  return PW'(LR_BASE) + PW'(bk);
    else                    return PW'(PC_SLOT);
  endfunction

  assign pa = phys(bank, rd_a_idx);
  assign pb = phys(bank, rd_b_idx);
  assign pw = phys(bank, wr_idx);
  assign pc_view = rf[PC_SLOT] + (narrow_isa ? NARROW_LOOKAHEAD : WIDE_LOOKAHEAD);

  assign rd_a_data = bad_mode ? '0 : (rd_a_idx == PC_IDX) ? pc_view : rf[pa];
  assign rd_b_data = bad_mode ? '0 : (rd_b_idx == PC_IDX) ? pc_view : rf[pb];

  always_ff @(posedge clk) begin
    if (rst)                      rf <= '0;
    else if (wr_en && !bad_mode)  rf[pw] <= wr_data;
  end

  a_r6_zero_reads: assert property (@(posedge clk) disable iff (rst)
    bad_mode |-> (rd_a_data == '0 && rd_b_data == '0));

  a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
    bad_mode |=> $stable(rf));

  a_r8_cleared: assert property (@(posedge clk)
    ($past(rst) && !rst && !bad_mode && rd_a_idx != PC_IDX) |-> rd_a_data == '0);

  a_r9_ports_agree: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == rd_b_idx) |-> rd_a_data == rd_b_data);

  a_r7_visible_next: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && wr_en && !bad_mode && wr_idx != PC_IDX) && !bad_mode &&
     mode == $past(mode) && rd_a_idx == $past(wr_idx)) |-> rd_a_data == $past(wr_data));

  a_r2_shared_low: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && wr_en && !bad_mode && wr_idx < IW'(SHARED_N)) && !bad_mode &&
     rd_b_idx == $past(wr_idx)) |-> rd_b_data == $past(wr_data));

  a_r5_pc_lookahead: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && wr_en && !bad_mode && wr_idx == PC_IDX) && !bad_mode && rd_a_idx == PC_IDX)
    |-> rd_a_data == $past(wr_data) + (narrow_isa ? NARROW_LOOKAHEAD : WIDE_LOOKAHEAD));

  a_r1_valid_code: assert property (@(posedge clk)
    !bad_mode |-> mode[4]);

endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  logic        clk = 0;
  logic        rst = 1;
  logic [4:0]  mode = 5'b10000;
  logic        narrow_isa = 0;
  logic [3:0]  rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = 0;
  logic        wr_en = 0;
  logic        bad_mode;

  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010, SVC = 5'b10011,
                         MON = 5'b10110, ABT = 5'b10111, UND = 5'b11011, SYS = 5'b11111;

  typedef struct packed {
    logic [31:0] ea;
    logic [31:0] eb;
    logic        ebad;
    logic [3:0]  req;
  } exp_t;

  exp_t q[$];
  event smp;
  int vecs = 0, bad = 0;
  bit done = 0;

  banked_regfile uut (.*);

  always #2 clk = ~clk;

  always begin
    @(smp);
    begin
      exp_t e;
      e = q.pop_front();
      vecs++;
      if (rd_a_data !== e.ea || rd_b_data !== e.eb || bad_mode !== e.ebad) begin
        bad++;
        $display("FAIL R%0d: a=%h b=%h bad=%b expected a=%h b=%h bad=%b",
                 e.req, rd_a_data, rd_b_data, bad_mode, e.ea, e.eb, e.ebad);
      end
    end
  end

  task automatic rd(input logic [4:0] m, input logic n, input logic [3:0] ia, input logic [3:0] ib,
                    input logic [31:0] ea, input logic [31:0] eb, input logic eb_bad, input int r);
    @(negedge clk);
    mode = m; narrow_isa = n; rd_a_idx = ia; rd_b_idx = ib;
    q.push_back('{ea: ea, eb: eb, ebad: eb_bad, req: 4'(r)});
    #1 ->smp;
  endtask

  task automatic wr(input logic [4:0] m, input logic [3:0] i, input logic [31:0] d);
    @(negedge clk);
    mode = m; wr_idx = i; wr_data = d; wr_en = 1;
    @(posedge clk);
    #1 wr_en = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst = 0;
    // R8: reset state, R5 PC reads 0+8
    rd(USR, 0, 4'd3, 4'd13, 0, 0, 0, 8);
    rd(USR, 0, 4'd15, 4'd10, 32'h8, 0, 0, 8);
    // R2: low register shared by every mode
    wr(USR, 4'd5, 32'h55);
    rd(FIQ, 0, 4'd5, 4'd5, 32'h55, 32'h55, 0, 2);
    rd(MON, 0, 4'd5, 4'd0, 32'h55, 0, 0, 2);
    // R3: fast-interrupt copies of 8..12
    wr(USR, 4'd9, 32'h900);
    wr(FIQ, 4'd9, 32'h9F);
    wr(SVC, 4'd12, 32'hC00);
    rd(USR, 0, 4'd9, 4'd12, 32'h900, 32'hC00, 0, 3);
    rd(FIQ, 0, 4'd9, 4'd12, 32'h9F, 0, 0, 3);
    rd(SYS, 0, 4'd9, 4'd9, 32'h900, 32'h900, 0, 3);
    // R4: seven stack/link banks, system shares user
    begin
      logic [4:0] ml[7] = '{USR, FIQ, IRQ, SVC, ABT, UND, MON};
      for (int k = 0; k < 7; k++) begin
        wr(ml[k], 4'd13, 32'hD00 + k);
        wr(ml[k], 4'd14, 32'hE00 + k);
      end
      for (int k = 0; k < 7; k++)
        rd(ml[k], 0, 4'd13, 4'd14, 32'hD00 + k, 32'hE00 + k, 0, 4);
      rd(SYS, 0, 4'd13, 4'd14, 32'hD00, 32'hE00, 0, 4);
    end
    // R5: PC look-ahead per instruction state
    wr(USR, 4'd15, 32'h1000);
    rd(USR, 0, 4'd15, 4'd15, 32'h1008, 32'h1008, 0, 5);
    rd(IRQ, 1, 4'd15, 4'd5, 32'h1004, 32'h55, 0, 5);
    // R1/R6: invalid codes flagged, reads zero
    rd(5'b00000, 0, 4'd5, 4'd15, 0, 0, 1, 1);
    rd(5'b10100, 0, 4'd9, 4'd13, 0, 0, 1, 1);
    rd(5'b11110, 0, 4'd5, 4'd5, 0, 0, 1, 6);
    rd(5'b01111, 0, 4'd5, 4'd5, 0, 0, 1, 1);
    // R6: write under invalid mode ignored
    wr(5'b00000, 4'd5, 32'hBAD);
    wr(5'b11100, 4'd15, 32'hBAD);
    rd(USR, 0, 4'd5, 4'd15, 32'h55, 32'h1008, 0, 6);
    // R7: read during write returns old, new value next cycle
    @(negedge clk);
    mode = USR; narrow_isa = 0; rd_a_idx = 4'd2; rd_b_idx = 4'd5;
    wr_idx = 4'd2; wr_data = 32'h22; wr_en = 1;
    q.push_back('{ea: 0, eb: 32'h55, ebad: 0, req: 4'd7});
    #1 ->smp;
    @(posedge clk);
    #1 wr_en = 0;
    rd(USR, 0, 4'd2, 4'd5, 32'h22, 32'h55, 0, 7);
    // R9: independent ports
    rd(FIQ, 0, 4'd14, 4'd9, 32'hE01, 32'h9F, 0, 9);
    rd(UND, 1, 4'd13, 4'd15, 32'hD05, 32'h1004, 0, 9);
    // R8: reset again clears everything
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    rd(FIQ, 0, 4'd9, 4'd5, 0, 0, 0, 8);
    rd(USR, 0, 4'd15, 4'd13, 32'h8, 0, 0, 8);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule